// File: doc/BRIEF.md
# Programmable Period-Increment Time Counter

This block keeps a free-running 64-bit time value for hardware timestamping. It does not count by one. It adds a programmable increment once every programmable number of clock cycles. The increment is scaled, so its low bits hold fractions of a nanosecond. A small period gives fine granularity. Changing the increment trims the rate while the period stays the same. A large scale factor brings the 64-bit wrap closer.

Software reaches the counter through a simple 32-bit register port that uses read and write strobes. The time is split into a low word and a high word:

- Reading the low word freezes the matching high word, so two reads give one coherent 64-bit sample.
- Writing the low word only stages it. Writing the high word then loads all 64 bits at once and restarts the period divider.
- A new increment configuration waits for the next period boundary before it takes effect, so the running time is never disturbed.

Top module: `tick_time_counter`

## Requirements
- R1: After reset the time is zero, the configuration reads zero and the read data is zero. With the zero increment the time stays at zero.
- R2: The configuration word (address 2) holds the period in bits 31:24 and the increment in bits 23:0. Once every period cycles, the zero-extended increment is added to the time, and the time is unchanged on all other cycles.
- R3: A period field of 0 behaves like a period of 1, so the time advances on every cycle.
- R4: The time wraps modulo 2^64 with no saturation.
- R5: Read data is registered. It appears on the cycle after a read strobe and is held while no read is made. Reading the low word (address 0) captures the high word into a shadow register. A later read of the high word (address 1) returns that shadow, not the live value.
- R6: Writing the low word does not change the time. Writing the high word loads {high data, staged low} as the time and restarts the period divider.
- R7: A configuration write is read back at once, but it reaches the counter only at the next period boundary. The time value is kept across the change.
- R8: Address 3 reads as zero, and writes to it have no effect.
- R9: When the accumulation crosses the low-word boundary, the carry enters the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address: 0 low time, 1 high time, 2 configuration, 3 unused |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Registered read data, valid the cycle after regRd |

## Verification
The bound checker watches four things on every cycle:
- the time moves only on a period tick or on a load;
- a tick adds exactly the active increment, modulo 2^64;
- the active configuration changes only at a boundary;
- a period of zero ticks every cycle.

It also checks that a load takes the high word from the bus, that read data holds when no read is made, and that address 3 reads zero.

Some behaviours need the bench's sequences and its cycle-accurate reference model:
- coherent two-word sampling;
- staging of the low word;
- deferral of a new configuration;
- carry into the high word;
- the wrap past 2^64.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  parameter int TIME_W   = 64;
  parameter int WORD_W   = 32;
  parameter int INC_W    = 24;
  parameter int PERIOD_W = 8;
  parameter int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] ADDR_LO  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_RSV = 2'd3;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic wrCfg;
    logic rdLo;
    logic rdHi;
    logic rdCfg;
    logic rdNone;
    logic tick;
  } ttcStrobes_t;
endpackage

// File: rtl/ttc_ctrl.sv
module ttc_ctrl
  import ttc_pkg::*;
#(
  parameter int PER_W = PERIOD_W,
  parameter int A_W   = ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [A_W-1:0]   regAddr,
  input  logic [PER_W-1:0] activePeriod,
  output ttcStrobes_t      strobes
);
  logic [PER_W-1:0] divCnt;
  logic [PER_W-1:0] lastCount;

  // a zero period behaves as a period of one
  always_comb begin
    if (activePeriod == '0) lastCount = '0;
    else                    lastCount = activePeriod - 1'b1;
  end

  always_comb begin
    strobes        = '0;
    strobes.wrLo   = regWr && (regAddr == ADDR_LO);
    strobes.wrHi   = regWr && (regAddr == ADDR_HI);
    strobes.wrCfg  = regWr && (regAddr == ADDR_CFG);
    strobes.rdLo   = regRd && (regAddr == ADDR_LO);
    strobes.rdHi   = regRd && (regAddr == ADDR_HI);
    strobes.rdCfg  = regRd && (regAddr == ADDR_CFG);
    strobes.rdNone = regRd && (regAddr == ADDR_RSV);
    strobes.tick   = (divCnt == lastCount);
  end

  always_ff @(posedge clk) begin
    if (rst)                              divCnt <= '0;
    else if (strobes.wrHi || strobes.tick) divCnt <= '0;
    else                                  divCnt <= divCnt + 1'b1;
  end
endmodule

// File: rtl/ttc_datapath.sv
module ttc_datapath
  import ttc_pkg::*;
#(
  parameter int T_W   = TIME_W,
  parameter int W_W   = WORD_W,
  parameter int I_W   = INC_W,
  parameter int PER_W = PERIOD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  ttcStrobes_t      strobes,
  input  logic [W_W-1:0]   wrData,
  output logic [W_W-1:0]   rdData,
  output logic [T_W-1:0]   timeNow,
  output logic [W_W-1:0]   activeCfg,
  output logic [PER_W-1:0] activePeriod
);
  localparam int HI_W = T_W - W_W;

  logic [W_W-1:0]  stageLo;
  logic [HI_W-1:0] shadowHi;
  logic [W_W-1:0]  cfgLast;
  logic            cfgPending;
  logic [T_W-1:0]  incExt;

  assign incExt       = {{(T_W-I_W){1'b0}}, activeCfg[I_W-1:0]};
  assign activePeriod = activeCfg[W_W-1 -: PER_W];

  // time accumulator and staged low word
  always_ff @(posedge clk) begin
    if (rst) begin
      timeNow <= '0;
      stageLo <= '0;
    end else begin
      if (strobes.wrLo) stageLo <= wrData;
      if (strobes.wrHi)      timeNow <= {wrData[HI_W-1:0], stageLo};
      else if (strobes.tick) timeNow <= timeNow + incExt;
    end
  end

  // configuration: last written value, applied at a period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      cfgLast    <= '0;
      cfgPending <= 1'b0;
      activeCfg  <= '0;
    end else begin
      if (strobes.tick && cfgPending) activeCfg <= cfgLast;
      if (strobes.wrCfg) begin
        cfgLast    <= wrData;
        cfgPending <= 1'b1;
      end else if (strobes.tick) begin
        cfgPending <= 1'b0;
      end
    end
  end

  // registered read port with high-word shadow
  always_ff @(posedge clk) begin
    if (rst) begin
      rdData   <= '0;
      shadowHi <= '0;
    end else begin
      if (strobes.rdLo) begin
        rdData   <= timeNow[W_W-1:0];
        shadowHi <= timeNow[T_W-1:W_W];
      end
      if (strobes.rdHi)   rdData <= shadowHi[W_W-1:0];
      if (strobes.rdCfg)  rdData <= cfgLast;
      if (strobes.rdNone) rdData <= '0;
    end
  end
endmodule

// File: rtl/tick_time_counter.sv
module tick_time_counter
  import ttc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData
);
  ttcStrobes_t         strobes;
  logic [TIME_W-1:0]   timeNow;
  logic [WORD_W-1:0]   activeCfg;
  logic [PERIOD_W-1:0] activePeriod;
  logic                periodTick;

  assign periodTick = strobes.tick;

  ttc_ctrl #(.PER_W(PERIOD_W), .A_W(ADDR_W)) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .regWr        (regWr),
    .regRd        (regRd),
    .regAddr      (regAddr),
    .activePeriod (activePeriod),
    .strobes      (strobes)
  );

  ttc_datapath #(.T_W(TIME_W), .W_W(WORD_W), .I_W(INC_W), .PER_W(PERIOD_W)) i_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .wrData       (regWrData),
    .rdData       (regRdData),
    .timeNow      (timeNow),
    .activeCfg    (activeCfg),
    .activePeriod (activePeriod)
  );
endmodule

// File: rtl/tick_time_counter_chk.sv
module tick_time_counter_chk
  import ttc_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                regWr,
  input logic                regRd,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [WORD_W-1:0]   regWrData,
  input logic [WORD_W-1:0]   regRdData,
  input logic [TIME_W-1:0]   timeNow,
  input logic [WORD_W-1:0]   activeCfg,
  input logic                periodTick
);
  logic loadHi;
  assign loadHi = regWr && (regAddr == ADDR_HI);

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !regRd |=> $stable(regRdData)); // R5

  AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (rst)
    loadHi |=> timeNow[TIME_W-1:WORD_W] == $past(regWrData)); // R6

  AST_TIME_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!periodTick && !loadHi) |=> $stable(timeNow)); // R2

  AST_TICK_ADD: assert property (@(posedge clk) disable iff (rst)
    (periodTick && !loadHi) |=>
      timeNow == $past(timeNow) + {{(TIME_W-INC_W){1'b0}}, $past(activeCfg[INC_W-1:0])}); // R4

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (regRd && regAddr == ADDR_RSV) |=> regRdData == '0); // R8

  AST_CFG_STEADY: assert property (@(posedge clk) disable iff (rst)
    !periodTick |=> $stable(activeCfg)); // R7

  AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (activeCfg[WORD_W-1 -: PERIOD_W] == '0) |-> periodTick); // R3
endmodule

bind tick_time_counter tick_time_counter_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .regWr      (regWr),
  .regRd      (regRd),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .regRdData  (regRdData),
  .timeNow    (timeNow),
  .activeCfg  (activeCfg),
  .periodTick (periodTick)
);

// File: tb/test_tick_time_counter.sv
module test_tick_time_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int    errors = 0;
  int    checks = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  tick_time_counter i_tick_time_counter (
    .clk(clk), .rst(rst), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  longint unsigned mTime;
  bit [31:0] mStage, mShadow, mCfg, mAct, mRd;
  bit        mPend;
  int        mCnt;

  always @(posedge clk) begin : model
    int per;
    bit tk;
    bit ld;
    if (rst) begin
      mTime = 0; mStage = 0; mShadow = 0; mCfg = 0; mAct = 0; mRd = 0;
      mPend = 0; mCnt = 0;
    end else begin
      per = int'(mAct[31:24]);
      if (per == 0) per = 1;
      tk = (mCnt == per - 1);
      ld = regWr && regAddr == 2'd1;
      if (regRd) begin
        case (regAddr)
          2'd0: begin mRd = mTime[31:0]; mShadow = mTime[63:32]; end
          2'd1: mRd = mShadow;
          2'd2: mRd = mCfg;
          default: mRd = 0;
        endcase
      end
      if (ld) mTime = {regWrData, mStage};
      else if (tk) mTime = mTime + longint'(mAct[23:0]);
      if (regWr && regAddr == 2'd0) mStage = regWrData;
      if (tk && mPend) mAct = mCfg;
      if (tk) mPend = 0;
      if (regWr && regAddr == 2'd2) begin mCfg = regWrData; mPend = 1; end
      mCnt = (ld || tk) ? 0 : mCnt + 1;
    end
  end

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (!rst && !done) chk({curReq, " model"}, regRdData, mRd);
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] a, b, c;
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdData", regRdData, 32'h0);
    rd(2'd0, a); chk("R1 low", a, 0);
    rd(2'd1, a); chk("R1 high", a, 0);
    rd(2'd2, a); chk("R1 cfg", a, 0);
    idle(12);
    rd(2'd0, a); chk("R1 stopped", a, 0);

    // R6 staged low write, load on high write
    curReq = "R6";
    wr(2'd0, 32'h1234_5678);
    rd(2'd0, a); chk("R6 staged", a, 0);
    wr(2'd1, 32'h0000_00AB);
    rd(2'd0, a); chk("R6 low", a, 32'h1234_5678);
    rd(2'd1, a); chk("R6 high", a, 32'h0000_00AB);

    // R8 unused address
    curReq = "R8";
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, a); chk("R8 read", a, 0);
    rd(2'd0, a); chk("R8 no effect low", a, 32'h1234_5678);
    rd(2'd2, a); chk("R8 no effect cfg", a, 0);

    // R2 period 4, increment 0x100
    curReq = "R2";
    wr(2'd2, {8'd4, 24'h000100});
    rd(2'd2, a); chk("R7 readback", a, {8'd4, 24'h000100});
    wr(2'd0, 0); wr(2'd1, 0);
    idle(41);
    rd(2'd0, a); chk("R2 stride", a & 32'hFF, 0);
    chk("R2 moving", (a != 0) ? 32'h1 : 32'h0, 32'h1);

    // R7 change config while running
    curReq = "R7";
    rd(2'd0, b);
    wr(2'd2, {8'd2, 24'h000010});
    idle(30);
    rd(2'd0, c);
    chk("R7 time kept", (c >= b) ? 32'h1 : 32'h0, 32'h1);

    // R3 period zero behaves as one
    curReq = "R3";
    wr(2'd2, {8'd0, 24'h000001});
    idle(10);
    rd(2'd0, a); rd(2'd0, b);
    chk("R3 every cycle", b - a, 32'd2);

    // R9 carry into high word
    curReq = "R9";
    wr(2'd2, {8'd1, 24'hFFFFFF});
    idle(4);
    wr(2'd0, 32'hFFFF_FF00); wr(2'd1, 32'h0);
    idle(10);
    rd(2'd0, a); rd(2'd1, b);
    chk("R9 carry", b, 32'h1);

    // R4 wrap past 2^64
    curReq = "R4";
    wr(2'd0, 32'hFFFF_FF00); wr(2'd1, 32'hFFFF_FFFF);
    idle(10);
    rd(2'd0, a); rd(2'd1, b);
    chk("R4 wrap", b, 32'h0);

    // R5 coherent sampling with shadow
    curReq = "R5";
    wr(2'd0, 32'hFFFF_FFF0); wr(2'd1, 32'h5);
    rd(2'd0, a);
    idle(20);
    rd(2'd1, b);
    idle(300);
    rd(2'd1, c);
    chk("R5 shadow held", c, b);
    idle(5);
    chk("R5 rdData held", regRdData, c);

    idle(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule